// File: doc/BRIEF.md
# Floating-Point Control and Status Register Pair

This block holds the two architectural registers that steer and report a single-precision floating-point unit. The control register carries the rounding-mode selector, which the block drives to the arithmetic datapath. The status register carries five sticky exception flags. Each cycle that the datapath delivers a result, it raises flags that are OR-ed into the sticky set. Software can write either register through a shared write port and reads each register on its own read port.

A write that sets any bit in the reserved upper field (bits 31:12) still completes with that field removed, and the block pulses a violation strobe for one cycle. A build-time parameter picks one of two variants. The standard variant keeps only the low control bits. The legacy variant keeps the upper control bits and drops only bits 11:7, and it raises no violation on control writes.

Top module: `fpcsr_top`

## Requirements
- R1: After synchronous reset both read ports return zero and the rounding mode output is 0 (nearest-even).
- R2: The rounding mode output equals control bits 1:0 (0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity) and updates in the cycle after the control write.
- R3: In the standard variant (LEGACY=0) a control write stores only bits 6:0, and every other bit reads back as zero.
- R4: In the legacy variant (LEGACY=1) a control write stores the written value ANDed with 0xFFFFF07F.
- R5: Status reads return the five sticky flags at bits 11:7 in the order inexact (bit 7), underflow, overflow, divide-by-zero, invalid (bit 11), with all other bits zero.
- R6: A status write replaces the sticky flags with written bits 11:7, and all other written bits are dropped.
- R7: When the result-valid input is high, the datapath flag vector (bit 0 inexact through bit 4 invalid) is OR-ed into the sticky flags. When it is low, the flags hold.
- R8: When a status write and a valid result fall in the same cycle, the written flags win and the datapath flags of that cycle are lost.
- R9: A status write, or a standard-variant control write, with any of bits 31:12 set pulses the violation output high for exactly the next cycle. Other writes leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status |
| wr_data | input | 32 | Write data |
| res_valid | input | 1 | Datapath produced a result this cycle |
| res_flags | input | 5 | Datapath exception flags (I,U,O,Z,V at bits 0..4) |
| ctrl_rdata | output | 32 | Control register read value |
| stat_rdata | output | 32 | Status register read value |
| round_mode | output | 2 | Rounding mode to the datapath |
| mbz_viol | output | 1 | One-cycle reserved-bit violation strobe |

## Verification
Every output comes from a register, so each write or flag input becomes visible one clock edge later. The bench drives inputs just after a falling edge. It advances a behavioural model at the rising edge and compares all four output groups against that model before the next rising edge, so each result is checked in the cycle it is due. The violation strobe is also checked to fall back to zero in the cycle after its pulse.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int XLEN      = 32;
  localparam int NFLAGS    = 5;
  localparam int FLAG_LSB  = 7;
  localparam int MBZ_LSB   = 12;
  localparam logic [XLEN-1:0] STD_CTRL_MASK = 32'h0000_007F;
  localparam logic [XLEN-1:0] OLD_CTRL_MASK = 32'hFFFF_F07F;
  typedef enum logic [1:0] {
    RND_NEAREST = 2'd0,
    RND_ZERO    = 2'd1,
    RND_UP      = 2'd2,
    RND_DOWN    = 2'd3
  } rnd_t;
  typedef enum logic { SEL_CTRL = 1'b0, SEL_STAT = 1'b1 } sel_t;
endpackage

// File: rtl/fpcsr_ctrl.sv
module fpcsr_ctrl
  import fpcsr_pkg::*;
#(
  parameter bit LEGACY = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] q
);
  logic [XLEN-1:0] mask;
  generate
    if (LEGACY) begin : g_old
      assign mask = OLD_CTRL_MASK;
    end else begin : g_std
      assign mask = STD_CTRL_MASK;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata & mask;
  end
endmodule

// File: rtl/fpcsr_flags.sv
module fpcsr_flags
  import fpcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [NFLAGS-1:0] wflags,
  input  logic              acc_en,
  input  logic [NFLAGS-1:0] acc_flags,
  output logic [NFLAGS-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (we)     q <= wflags;
    else if (acc_en) q <= q | acc_flags;
  end
endmodule

// File: rtl/fpcsr_top.sv
module fpcsr_top
  import fpcsr_pkg::*;
#(
  parameter bit LEGACY = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              res_valid,
  input  logic [NFLAGS-1:0] res_flags,
  output logic [XLEN-1:0]   ctrl_rdata,
  output logic [XLEN-1:0]   stat_rdata,
  output logic [1:0]        round_mode,
  output logic              mbz_viol
);
  localparam int FLAG_MSB = FLAG_LSB + NFLAGS - 1;

  logic ctrl_we, stat_we, upper_set, viol_d;
  logic [NFLAGS-1:0] flags_q;

  assign ctrl_we   = wr_en && (sel_t'(wr_sel) == SEL_CTRL);
  assign stat_we   = wr_en && (sel_t'(wr_sel) == SEL_STAT);
  assign upper_set = |wr_data[XLEN-1:MBZ_LSB];
  assign viol_d    = upper_set && (stat_we || (ctrl_we && !LEGACY));

  fpcsr_ctrl #(.LEGACY(LEGACY)) u_ctrl (
    .clk(clk), .rst(rst), .we(ctrl_we), .wdata(wr_data), .q(ctrl_rdata)
  );

  fpcsr_flags u_flags (
    .clk(clk), .rst(rst), .we(stat_we),
    .wflags(wr_data[FLAG_MSB:FLAG_LSB]),
    .acc_en(res_valid), .acc_flags(res_flags), .q(flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) mbz_viol <= 1'b0;
    else     mbz_viol <= viol_d;
  end

  assign round_mode = ctrl_rdata[1:0];
  always_comb begin
    stat_rdata = '0;
    stat_rdata[FLAG_MSB:FLAG_LSB] = flags_q;
  end
endmodule

// File: rtl/fpcsr_chk.sv
module fpcsr_chk
  import fpcsr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [XLEN-1:0]   wr_data,
  input logic              res_valid,
  input logic [NFLAGS-1:0] res_flags,
  input logic [XLEN-1:0]   ctrl_rdata,
  input logic [XLEN-1:0]   stat_rdata,
  input logic              mbz_viol
);
  assert_stat_clean_R5: assert property (@(posedge clk) disable iff (rst)
    (stat_rdata[XLEN-1:MBZ_LSB] == '0) && (stat_rdata[FLAG_LSB-1:0] == '0));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !(wr_en && wr_sel)) |=>
      ((stat_rdata[11:7] & $past(res_flags)) == $past(res_flags)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!res_valid && !wr_en) |=> $stable(stat_rdata) && $stable(ctrl_rdata));

  assert_wr_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> stat_rdata[11:7] == $past(wr_data[11:7]));

  assert_no_viol_R9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && |wr_data[31:12]) |=> !mbz_viol);

  assert_viol_stat_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && |wr_data[31:12]) |=> mbz_viol);

  assert_ctrl_low_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel) |=> ctrl_rdata[1:0] == $past(wr_data[1:0]));
endmodule

bind fpcsr_top fpcsr_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .res_valid(res_valid), .res_flags(res_flags), .ctrl_rdata(ctrl_rdata),
  .stat_rdata(stat_rdata), .mbz_viol(mbz_viol)
);

// File: tb/fpcsr_top_test.sv
module fpcsr_top_test;
  logic clk = 0, rst = 1;
  logic wr_en = 0, wr_sel = 0, res_valid = 0;
  logic [31:0] wr_data = 0;
  logic [4:0] res_flags = 0;
  logic [31:0] c_s, s_s, c_l, s_l;
  logic [1:0] rm_s, rm_l;
  logic v_s, v_l;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fpcsr_top #(.LEGACY(1'b0)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .res_valid(res_valid), .res_flags(res_flags), .ctrl_rdata(c_s),
    .stat_rdata(s_s), .round_mode(rm_s), .mbz_viol(v_s));
  fpcsr_top #(.LEGACY(1'b1)) uut_legacy (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .res_valid(res_valid), .res_flags(res_flags), .ctrl_rdata(c_l),
    .stat_rdata(s_l), .round_mode(rm_l), .mbz_viol(v_l));

  // behavioural reference
  longint m_cs, m_cl, m_fl;
  bit m_vs, m_vl;
  always @(posedge clk) begin
    if (rst) begin
      m_cs = 0; m_cl = 0; m_fl = 0; m_vs = 0; m_vl = 0;
    end else begin
      m_vs = 0; m_vl = 0;
      if (wr_en && !wr_sel) begin
        m_cs = wr_data % 128;
        m_cl = wr_data - (wr_data & 32'hF80);
        m_vs = (wr_data >= 4096);
      end
      if (wr_en && wr_sel) begin
        m_fl = (wr_data / 128) % 32;
        m_vs = (wr_data >= 4096);
        m_vl = m_vs;
      end else if (res_valid) m_fl = m_fl | res_flags;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    chk("R2/R3 ctrl std", c_s, m_cs);
    chk("R4 ctrl legacy", c_l, m_cl);
    chk("R2 round std", rm_s, m_cs % 4);
    chk("R2 round legacy", rm_l, m_cl % 4);
    chk("R5/R6/R7/R8 stat std", s_s, m_fl * 128);
    chk("R5 stat legacy", s_l, m_fl * 128);
    chk("R9 viol std", v_s, m_vs);
    chk("R9 viol legacy", v_l, m_vl);
  end

  task automatic wr(bit sel, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d; res_valid = 0;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic res(logic [4:0] f);
    @(negedge clk); res_valid = 1; res_flags = f;
    @(negedge clk); res_valid = 0;
  endtask

  initial begin : watchdog
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ctrl", c_s, 0); chk("R1 stat", s_s, 0);
    chk("R1 round", rm_s, 0); chk("R1 viol", v_s, 0);
    rst = 0;
    for (int m = 0; m < 4; m++) wr(0, m);            // R2 all modes
    wr(0, 32'h0000_0FFF);                            // R3/R4 low field
    wr(0, 32'hABCD_E5A6);                            // R3/R4/R9 upper bits
    wr(0, 32'h0000_0001);
    res(5'b00001); res(5'b10000); res(5'b00100);     // R7 accumulate
    @(negedge clk); res_valid = 0; res_flags = 5'b11111; // R7 ignored when invalid
    @(negedge clk);
    wr(1, 32'h0000_0000);                            // R6 clear
    wr(1, 32'h0000_0A80);                            // R6 set I,O,V
    wr(1, 32'h0000_107F);                            // R6/R9 drop non-flag bits
    res(5'b01010);
    // R8: write and result same cycle
    @(negedge clk); wr_en = 1; wr_sel = 1; wr_data = 32'h0000_0100;
    res_valid = 1; res_flags = 5'b11111;
    @(negedge clk); wr_en = 0; res_valid = 0;
    wr(1, 32'hFFFF_FFFF);                            // R9 status violation
    for (int i = 0; i < 20; i++) begin
      if (i % 3 == 0) wr(i % 2, 32'h1357_9BDF * i);
      else res(5'(i * 7));
    end
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule